// File: doc/BRIEF.md
# Buffered Block Serial Port with Chip Select

This block is a synchronous serial port that moves a whole block of bytes after one start command. The host loads up to 32 bytes into an internal buffer and sets a byte count and a clock mode. It then pulses start. The port shifts the bytes out one after another. Each byte received in exchange is written back over the buffer slot that the outgoing byte came from. When the last byte is done, a one-cycle completion pulse fires.

The serial clock either comes from the block (master, one period every eight system clocks) or from outside (slave). The serial clock idles low. Received data is taken on the rising serial-clock edge, and outgoing data moves on the falling edge. An active-low chip-select input gates the transfer. While it is high, the data output and the driven clock are released, and the master clock stops. In slave mode, releasing chip select in the middle of a byte ends the transfer with an error flag.

Top module: `blkser_port`

## Requirements
- R1: After reset, busy, done, xfer_err, sdo_oe and sck_oe are all 0.
- R2: While busy is 0, a buf_we cycle stores buf_wdata at index buf_addr, and buf_rdata always shows the byte stored at buf_addr.
- R3: A start pulse while idle transfers exactly len_m1+1 bytes (1 to 32). After the last byte, done is high for exactly one cycle and busy is 0 in that cycle.
- R4: Bytes are sent from buffer index 0 upward, each most significant bit first, on sdo.
- R5: The byte received during the transfer of index i is stored at index i, first received bit as bit 7.
- R6: sdi is taken at the rising serial-clock edge, and sdo changes only after a falling edge, never while the serial clock is high.
- R7: With mode_master=1, sck_out has a period of DIV (8) clocks, starts low, and sck_oe is 1 only in master mode. With mode_master=0, the port follows sck_in, which idles low.
- R8: While cs_n is high, sdo_oe and sck_oe are 0. In master mode the transfer pauses and then resumes with no lost bits.
- R9: In slave mode, cs_n rising after at least one rising clock edge of an unfinished byte clears busy and sets xfer_err without a done pulse. The next start clears xfer_err.
- R10: buf_we and start are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block transfer (one cycle) |
| len_m1 | input | 5 | Byte count minus one |
| mode_master | input | 1 | 1 = drive serial clock, 0 = follow sck_in |
| buf_we | input | 1 | Buffer write strobe |
| buf_addr | input | 5 | Buffer index for read and write |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer byte at buf_addr |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| xfer_err | output | 1 | Slave transfer aborted by chip select |
| cs_n | input | 1 | Chip select, active low |
| sck_in | input | 1 | Serial clock in slave mode |
| sck_out | output | 1 | Serial clock in master mode |
| sck_oe | output | 1 | Enable for sck_out |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Enable for sdo |

## Verification
The block transfer is run with random buffer contents and random incoming bytes. It is tried with the shortest length (1), the full length (32) and random lengths in master mode, and with several lengths in slave mode. Comparing the bytes seen on sdo with the buffer, and the buffer afterwards with the bytes sent in, separates errors in bit order, in pointer stepping and in write-back location. A chip-select pause in master mode shows that no bits are lost or repeated. A mid-byte release in slave mode checks the abort path. Writes and restarts issued during a transfer must leave the buffer slots outside the transfer and the transfer itself untouched.

// File: rtl/blkser_port.sv
module blkser_port #(
  parameter int DEPTH = 32,
  parameter int DIV = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] len_m1,
  input  logic          mode_master,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          busy,
  output logic          done,
  output logic          xfer_err,
  input  logic          cs_n,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int HALF = DIV / 2;
  localparam int PW = $clog2(DIV);

  logic [7:0]    mem [DEPTH];
  logic [2:0]    cs_p, sck_p;
  logic [1:0]    sdi_p;
  logic          master_q, mid;
  logic [PW-1:0] ph;
  logic [2:0]    bitn;
  logic [AW-1:0] ptr, cnt;
  logic [7:0]    tx, rx;

  wire cs_s = cs_p[1];
  wire go = busy & ~cs_s;
  wire rise = go & (master_q ? (ph == PW'(HALF - 1)) : (sck_p[1] & ~sck_p[2]));
  wire fall = go & (master_q ? (ph == PW'(DIV - 1)) : (~sck_p[1] & sck_p[2]));
  wire abort = busy & ~master_q & mid & cs_s & ~cs_p[2];
  wire byte_end = fall & (bitn == 3'd7);

  assign buf_rdata = mem[buf_addr];
  assign sck_out = master_q & busy & (ph >= PW'(HALF));
  assign sck_oe = master_q & go;
  assign sdo = tx[7];
  assign sdo_oe = go;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= 3'b111;
      sck_p <= 3'b000;
      sdi_p <= 2'b00;
    end else begin
      cs_p <= {cs_p[1:0], cs_n};
      sck_p <= {sck_p[1:0], sck_in};
      sdi_p <= {sdi_p[0], sdi};
    end

  always_ff @(posedge clk) begin
    if (!busy && buf_we) mem[buf_addr] <= buf_wdata;
    else if (byte_end) mem[ptr] <= rx;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      xfer_err <= 1'b0;
      master_q <= 1'b0;
      mid <= 1'b0;
      ph <= '0;
      bitn <= '0;
      ptr <= '0;
      cnt <= '0;
      tx <= '0;
      rx <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        master_q <= mode_master;
        xfer_err <= 1'b0;
        ptr <= '0;
        cnt <= len_m1;
        tx <= mem[0];
        bitn <= '0;
        mid <= 1'b0;
        ph <= '0;
      end else if (abort) begin
        busy <= 1'b0;
        xfer_err <= 1'b1;
      end else if (busy) begin
        if (master_q && go) ph <= (ph == PW'(DIV - 1)) ? '0 : ph + 1'b1;
        if (rise) begin
          rx <= {rx[6:0], sdi_p[1]};
          mid <= 1'b1;
        end
        if (fall) begin
          bitn <= bitn + 1'b1;
          if (bitn == 3'd7) begin
            mid <= 1'b0;
            if (cnt == '0) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              ptr <= ptr + 1'b1;
              cnt <= cnt - 1'b1;
              tx <= mem[AW'(ptr + 1'b1)];
            end
          end else begin
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sck_out && $past(sck_out)) |-> $stable(sdo)); // R6
  AST_NO_SLAVE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !master_q) |-> !sck_oe); // R7
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_err) |-> (!busy && !done)); // R9
endmodule

// File: tb/blkser_port_tb.sv
module blkser_port_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0, mode_master = 0, buf_we = 0;
  logic [4:0] len_m1 = 0, buf_addr = 0;
  logic [7:0] buf_wdata = 0, buf_rdata;
  logic busy, done, xfer_err;
  logic cs_n = 1, sck_in = 0, sdi = 0;
  logic sck_out, sck_oe, sdo, sdo_oe;

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;
  logic [7:0] tx_b [32];
  logic [7:0] in_b [32];
  logic [7:0] got_b [32];

  blkser_port u_dut (.clk, .rst_n, .start, .len_m1, .mode_master, .buf_we, .buf_addr,
    .buf_wdata, .buf_rdata, .busy, .done, .xfer_err, .cs_n, .sck_in, .sck_out, .sck_oe,
    .sdi, .sdo, .sdo_oe);

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); buf_we = 1; buf_addr = a; buf_wdata = d;
    @(negedge clk); buf_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); buf_addr = a; #1 d = buf_rdata;
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) begin
      tx_b[i] = 8'($urandom);
      in_b[i] = 8'($urandom);
      wr(5'(i), tx_b[i]);
    end
  endtask

  task automatic kick(input int len, input logic m);
    @(negedge clk); start = 1; len_m1 = 5'(len - 1); mode_master = m;
    @(negedge clk); start = 0;
    chk("R9 err cleared by start", {31'd0, xfer_err}, 0);
  endtask

  task automatic compare(input int len, input string tag);
    int bad_tx = 0, bad_rx = 0;
    logic [7:0] d;
    for (int i = 0; i < len; i++) begin
      if (got_b[i] !== tx_b[i]) bad_tx++;
      rd(5'(i), d);
      if (d !== in_b[i]) bad_rx++;
    end
    chk({"R4 sent bytes ", tag}, bad_tx, 0);
    chk({"R5 written back ", tag}, bad_rx, 0);
  endtask

  task automatic master_run(input int len, input int pause_at, input bit disturb);
    int dc0, r0 = 0, r1 = 0;
    logic [7:0] d;
    fill(len);
    if (disturb) wr(5'd31, 8'h5A);
    dc0 = done_cnt;
    cs_n = 0;
    sdi = in_b[0][7];
    kick(len, 1);
    fork
      begin
        for (int k = 0; k < 8 * len; k++) begin
          @(posedge sck_out);
          if (k == 0) r0 = cyc;
          if (k == 1) r1 = cyc;
          got_b[k / 8][7 - (k % 8)] = sdo;
          if (k == pause_at) begin
            @(negedge clk); cs_n = 1;
            repeat (6) @(negedge clk);
            chk("R8 sck_oe released", {31'd0, sck_oe}, 0);
            chk("R8 sdo_oe released", {31'd0, sdo_oe}, 0);
            chk("R8 paused not ended", {31'd0, busy}, 1);
            cs_n = 0;
          end
          @(negedge sck_out);
          if (k + 1 < 8 * len) sdi = in_b[(k + 1) / 8][7 - ((k + 1) % 8)];
        end
      end
      begin
        if (disturb) begin
          repeat (3) @(negedge clk);
          buf_we = 1; buf_addr = 5'd31; buf_wdata = 8'hA5; start = 1;
          @(negedge clk); buf_we = 0; start = 0;
        end
      end
    join
    repeat (2) @(negedge clk);
    chk("R3 one done pulse", done_cnt - dc0, 1);
    chk("R3 idle after done", {31'd0, busy}, 0);
    if (len > 1) chk("R7 master period", r1 - r0, 8);
    compare(len, "master");
    if (disturb) begin
      rd(5'd31, d);
      chk("R10 write during busy ignored", {24'd0, d}, 8'h5A);
    end
  endtask

  task automatic slave_run(input int len, input int abort_at);
    int dc0;
    bit aborted = 0;
    logic [7:0] d;
    fill(len);
    dc0 = done_cnt;
    kick(len, 0);
    @(negedge clk); cs_n = 0; sck_in = 0;
    for (int k = 0; k < 8 * len; k++) begin
      sdi = in_b[k / 8][7 - (k % 8)];
      repeat (8) @(negedge clk);
      got_b[k / 8][7 - (k % 8)] = sdo;
      chk("R7 slave no clock drive", {31'd0, sck_oe}, 0);
      sck_in = 1;
      repeat (8) @(negedge clk);
      if (k == abort_at) begin
        cs_n = 1; aborted = 1;
        repeat (4) @(negedge clk);
        sck_in = 0;
        break;
      end
      sck_in = 0;
    end
    if (!aborted) begin
      repeat (8) @(negedge clk);
      cs_n = 1;
      repeat (4) @(negedge clk);
      chk("R8 sdo_oe off with cs high", {31'd0, sdo_oe}, 0);
      chk("R3 slave one done pulse", done_cnt - dc0, 1);
      chk("R3 slave idle", {31'd0, busy}, 0);
      compare(len, "slave");
    end else begin
      repeat (4) @(negedge clk);
      chk("R9 abort clears busy", {31'd0, busy}, 0);
      chk("R9 abort sets err", {31'd0, xfer_err}, 1);
      chk("R9 no done on abort", done_cnt - dc0, 0);
      rd(5'd0, d);
      chk("R5 completed byte kept", {24'd0, d}, {24'd0, in_b[0]});
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int bad = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 err", {31'd0, xfer_err}, 0);
    chk("R1 oe", {30'd0, sdo_oe, sck_oe}, 0);
    rst_n = 1;
    fill(32);
    for (int i = 0; i < 32; i++) begin
      rd(5'(i), d);
      if (d !== tx_b[i]) bad++;
    end
    chk("R2 buffer readback", bad, 0);
    master_run(5, 11, 1);
    master_run(1, -1, 0);
    master_run(32, 100, 0);
    for (int t = 0; t < 3; t++) master_run(2 + int'($urandom % 9), -1, 1);
    slave_run(4, -1);
    slave_run(1, -1);
    slave_run(3, 11);
    master_run(2, -1, 0);
    slave_run(2 + int'($urandom % 4), -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule